// File: doc/BRIEF.md
# Dual-Channel Fault Protection Supervisor

This block watches two buck converter channels and decides when both must be switched off. Each channel supplies digital comparator flags: undervoltage (feedback below 85% of the reference), overvoltage (feedback above 115% of the reference) and overcurrent. A single overtemperature flag reports a junction above 150 °C. A one-clock strobe marks each switching cycle. Undervoltage and overcurrent events are counted in two separate 4-bit counters. Either counter overflowing, or the temperature flag, raises one shutdown output that turns off both channels.

The two counters behave differently. Each adds the number of channels at fault in a strobed cycle, so it steps by one or two. The undervoltage counter keeps its total through clean cycles. The overcurrent counter returns to zero on the first strobed cycle with no overcurrent. An overvoltage flag never shuts anything down. Instead it raises that channel's pull-down request, so the output is driven back to its target. Once shut down, the block stays off until a synchronous clear or reset is applied. Either one zeroes both counters, the overflow bits and the thermal latch.

Top module: `fault_supervisor`

## Requirements
- R1: After reset is applied, `conv_off`, `latched_off`, `ov_pulldown`, `uv_count` and `oc_count` are all zero.
- R2: On a clock where `cyc_stb` is 1, `uv_count` increases by the number of bits set in `uv_flag` (0, 1 or 2). On a clock where `cyc_stb` is 0, neither counter changes, whatever the flags are.
- R3: A strobed cycle with `uv_flag` = 0 leaves `uv_count` unchanged, so undervoltage events accumulate across clean cycles.
- R4: If the undervoltage sum would exceed 15 (15+1, 14+2 or 15+2), the undervoltage overflow is latched, `uv_count` holds at 15, and `conv_off` is 1 from the next clock.
- R5: On a clock where `cyc_stb` is 1 and `oc_flag` is non-zero, `oc_count` increases by the number of bits set in `oc_flag`.
- R6: A strobed cycle with `oc_flag` = 0 sets `oc_count` to 0, provided the overcurrent counter has not overflowed.
- R7: If the overcurrent sum would exceed 15, the overcurrent overflow is latched, `oc_count` holds at 15, and `conv_off` is 1 from the next clock.
- R8: If `ot_flag` is 1 on any clock, `latched_off` and `conv_off` become 1 on the next clock. Both stay at 1 after the flag drops.
- R9: While `conv_off` is 0, `ov_pulldown[i]` equals `ov_flag[i]` sampled one clock earlier. Overvoltage never changes `conv_off`, `uv_count` or `oc_count`.
- R10: While `conv_off` is 1, both counters are frozen and `ov_pulldown` is 0 from the next clock.
- R11: A clock with `fault_clr` = 1 returns every output to the reset state of R1 on the next clock. This takes priority over all other inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_clr | input | 1 | Synchronous restart: clears shutdown, latches and counters |
| cyc_stb | input | 1 | One-clock marker of a switching cycle |
| uv_flag | input | NCH (2) | Per-channel undervoltage comparator flag |
| ov_flag | input | NCH (2) | Per-channel overvoltage comparator flag |
| oc_flag | input | NCH (2) | Per-channel overcurrent comparator flag |
| ot_flag | input | 1 | Overtemperature flag |
| conv_off | output | 1 | Shutdown of both channels |
| ov_pulldown | output | NCH (2) | Per-channel overvoltage pull-down request |
| latched_off | output | 1 | Thermal latch-off status |
| uv_count | output | CW (4) | Undervoltage event counter |
| oc_count | output | CW (4) | Overcurrent event counter |

## Verification
The counters are driven with single-channel and dual-channel fault strobes, which separates a step of one from a step of two. Unstrobed cycles carrying active flags show that only the strobe advances a count. Clean strobes are applied to both counters: they must leave the undervoltage total in place and zero the overcurrent total, which exposes any mix-up of the two counting rules. Overflow is reached both by 15+1 and by 14+2. Pulses of overvoltage and temperature, sent both before and after shutdown, separate the pull-down path from the shutdown latches.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  // Number of set bits in a flag vector (channels at fault this cycle).
  function automatic int unsigned hit_count(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      n += 32'(v[i]);
    end
    return n;
  endfunction

endpackage

// File: rtl/fault_event_counter.sv
module fault_event_counter
  import fsup_pkg::*;
#(
  parameter int NCH           = 2,
  parameter int W             = 4,
  parameter bit CLEAR_ON_IDLE = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           en,
  input  logic [NCH-1:0] hits,
  output logic [W-1:0]   count,
  output logic           ovf
);

  localparam int SW = W + $clog2(NCH + 1);
  localparam logic [SW-1:0] MAXV = SW'((1 << W) - 1);

  logic [SW-1:0] sum;
  logic          idle_clear;

  always_comb begin
    sum = SW'(count) + SW'(hit_count(32'(hits)));
  end

  generate
    if (CLEAR_ON_IDLE) begin : g_clear_idle
      assign idle_clear = (hits == '0);
    end else begin : g_accumulate
      assign idle_clear = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (en && !ovf) begin
      if (idle_clear) begin
        count <= '0;
      end else if (sum > MAXV) begin
        ovf   <= 1'b1;
        count <= MAXV[W-1:0];
      end else begin
        count <= sum[W-1:0];
      end
    end
  end

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(count)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr) |=> ovf); // R4
  AST_OVF_SATURATED: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (count == MAXV[W-1:0])); // R7

  generate
    if (CLEAR_ON_IDLE) begin : g_idle_chk
      AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && !ovf && hits == '0) |=> (count == '0)); // R6
    end
  endgenerate

endmodule

// File: rtl/ov_clamp.sv
module ov_clamp #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           block,
  input  logic [NCH-1:0] ov_flag,
  output logic [NCH-1:0] pd_req
);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst || clr || block) pd_req[c] <= 1'b0;
        else                     pd_req[c] <= ov_flag[c];
      end
    end
  endgenerate

  AST_PD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!block && !clr) |=> (pd_req == $past(ov_flag))); // R9
  AST_PD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    block |=> (pd_req == '0)); // R10

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int NCH = 2,
  parameter int CW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fault_clr,
  input  logic           cyc_stb,
  input  logic [NCH-1:0] uv_flag,
  input  logic [NCH-1:0] ov_flag,
  input  logic [NCH-1:0] oc_flag,
  input  logic           ot_flag,
  output logic           conv_off,
  output logic [NCH-1:0] ov_pulldown,
  output logic           latched_off,
  output logic [CW-1:0]  uv_count,
  output logic [CW-1:0]  oc_count
);

  logic uv_ovf, oc_ovf, ot_q, cnt_en;

  // All shutdown sources are flops; the OR only merges them.
  assign conv_off    = uv_ovf | oc_ovf | ot_q;
  assign latched_off = ot_q;
  assign cnt_en      = cyc_stb & ~conv_off;

  fault_event_counter #(.NCH(NCH), .W(CW), .CLEAR_ON_IDLE(1'b0)) u_uv_cnt (
    .clk(clk), .rst(rst), .clr(fault_clr), .en(cnt_en), .hits(uv_flag),
    .count(uv_count), .ovf(uv_ovf)
  );

  fault_event_counter #(.NCH(NCH), .W(CW), .CLEAR_ON_IDLE(1'b1)) u_oc_cnt (
    .clk(clk), .rst(rst), .clr(fault_clr), .en(cnt_en), .hits(oc_flag),
    .count(oc_count), .ovf(oc_ovf)
  );

  ov_clamp #(.NCH(NCH)) u_ov (
    .clk(clk), .rst(rst), .clr(fault_clr), .block(conv_off),
    .ov_flag(ov_flag), .pd_req(ov_pulldown)
  );

  always_ff @(posedge clk) begin
    if (rst || fault_clr) ot_q <= 1'b0;
    else if (ot_flag)     ot_q <= 1'b1;
  end

  AST_OT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (ot_flag && !fault_clr) |=> (latched_off && conv_off)); // R8
  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (rst)
    fault_clr |=> (!conv_off && uv_count == '0 && oc_count == '0)); // R11
  AST_SHUTDOWN_HELD: assert property (@(posedge clk) disable iff (rst)
    (conv_off && !fault_clr) |=> conv_off); // R10

endmodule

// File: tb/tb_fault_supervisor.sv
module tb_fault_supervisor;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fault_clr = 1'b0;
  logic       cyc_stb = 1'b0;
  logic [1:0] uv_flag = '0, ov_flag = '0, oc_flag = '0;
  logic       ot_flag = 1'b0;
  logic       conv_off, latched_off;
  logic [1:0] ov_pulldown;
  logic [3:0] uv_count, oc_count;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int m_uv = 0, m_oc = 0, m_pd = 0;
  bit m_uvo = 0, m_oco = 0, m_ot = 0;

  always #2.5 clk = ~clk;

  fault_supervisor dut (
    .clk(clk), .rst(rst), .fault_clr(fault_clr), .cyc_stb(cyc_stb),
    .uv_flag(uv_flag), .ov_flag(ov_flag), .oc_flag(oc_flag), .ot_flag(ot_flag),
    .conv_off(conv_off), .ov_pulldown(ov_pulldown), .latched_off(latched_off),
    .uv_count(uv_count), .oc_count(oc_count)
  );

  function automatic int ones(input logic [1:0] v);
    return int'(v[0]) + int'(v[1]);
  endfunction

  always @(posedge clk) begin
    if (rst || fault_clr) begin
      m_uv = 0; m_oc = 0; m_pd = 0; m_uvo = 0; m_oco = 0; m_ot = 0;
    end else begin
      bit off;
      off = m_uvo || m_oco || m_ot;
      if (!off && cyc_stb) begin
        if (!m_uvo) begin
          if (m_uv + ones(uv_flag) > 15) begin m_uvo = 1; m_uv = 15; end
          else m_uv = m_uv + ones(uv_flag);
        end
        if (!m_oco) begin
          if (ones(oc_flag) == 0) m_oc = 0;
          else if (m_oc + ones(oc_flag) > 15) begin m_oco = 1; m_oc = 15; end
          else m_oc = m_oc + ones(oc_flag);
        end
      end
      if (ot_flag) m_ot = 1;
      m_pd = off ? 0 : int'(ov_flag);
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      chk(int'(uv_count), m_uv, "R2 R3 R4 uv_count");
      chk(int'(oc_count), m_oc, "R5 R6 R7 oc_count");
      chk(int'(conv_off), int'(m_uvo || m_oco || m_ot), "R4 R7 R8 conv_off");
      chk(int'(latched_off), int'(m_ot), "R8 latched_off");
      chk(int'(ov_pulldown), m_pd, "R9 R10 ov_pulldown");
    end
  end

  task automatic drive(input bit stb, input logic [1:0] uv, input logic [1:0] oc,
                       input logic [1:0] ov, input bit ot, input bit clr);
    @(negedge clk);
    cyc_stb = stb; uv_flag = uv; oc_flag = oc; ov_flag = ov; ot_flag = ot; fault_clr = clr;
  endtask

  task automatic settle;
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    chk(int'({conv_off, latched_off, ov_pulldown, uv_count, oc_count}), 0, "R1 reset state");

    // R2: single then dual undervoltage, unstrobed flags ignored
    drive(1, 2'b01, 0, 0, 0, 0); settle(); chk(uv_count, 1, "R2 step of one");
    drive(1, 2'b11, 0, 0, 0, 0); settle(); chk(uv_count, 3, "R2 step of two");
    drive(0, 2'b11, 2'b11, 0, 0, 0); settle(); chk(uv_count, 3, "R2 no strobe");
    drive(1, 2'b00, 0, 0, 0, 0); settle(); chk(uv_count, 3, "R3 clean strobe keeps");
    drive(1, 2'b10, 0, 0, 0, 0); settle(); chk(uv_count, 4, "R2 channel 1 step");

    // R5, R6: overcurrent
    drive(1, 0, 2'b01, 0, 0, 0); settle(); chk(oc_count, 1, "R5 step of one");
    drive(1, 0, 2'b11, 0, 0, 0); settle(); chk(oc_count, 3, "R5 step of two");
    drive(1, 0, 2'b00, 0, 0, 0); settle(); chk(oc_count, 0, "R6 clear on idle");

    // R9: overvoltage only requests pull-down
    drive(0, 0, 0, 2'b10, 0, 0); settle();
    chk(ov_pulldown, 2, "R9 pull-down"); chk(conv_off, 0, "R9 no shutdown");
    drive(1, 0, 0, 2'b01, 0, 0); settle();
    chk(ov_pulldown, 1, "R9 pull-down ch0"); chk(uv_count, 4, "R9 counts untouched");

    // R4: 14 + 2 overflow
    for (int i = 0; i < 5; i++) drive(1, 2'b11, 0, 0, 0, 0);
    settle(); chk(uv_count, 14, "R4 pre-overflow"); chk(conv_off, 0, "R4 not yet off");
    drive(1, 2'b11, 0, 0, 0, 0); settle();
    chk(conv_off, 1, "R4 14+2 overflow"); chk(uv_count, 15, "R4 saturated");

    // R10: frozen while off
    drive(1, 0, 2'b11, 2'b11, 0, 0); settle(); settle();
    chk(oc_count, 0, "R10 oc frozen"); chk(ov_pulldown, 0, "R10 pull-down off");

    // R11 then R4 via 15 + 1
    drive(0, 0, 0, 0, 0, 1); settle();
    chk(int'({conv_off, uv_count, oc_count}), 0, "R11 clear");
    for (int i = 0; i < 15; i++) drive(1, 2'b01, 0, 0, 0, 0);
    settle(); chk(uv_count, 15, "R4 reaches 15"); chk(conv_off, 0, "R4 15 is not overflow");
    drive(1, 2'b10, 0, 0, 0, 0); settle(); chk(conv_off, 1, "R4 15+1 overflow");

    // R7: overcurrent overflow
    drive(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 7; i++) drive(1, 0, 2'b11, 0, 0, 0);
    drive(1, 0, 2'b01, 0, 0, 0); settle(); chk(oc_count, 15, "R7 reaches 15");
    drive(1, 0, 2'b10, 0, 0, 0); settle();
    chk(conv_off, 1, "R7 overflow"); chk(latched_off, 0, "R7 not thermal");
    drive(1, 0, 2'b00, 0, 0, 0); settle(); chk(oc_count, 15, "R7 idle ignored after overflow");

    // R8: thermal latch
    drive(0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 1, 0); settle();
    chk(latched_off, 1, "R8 latch"); chk(conv_off, 1, "R8 shutdown");
    drive(0, 0, 0, 0, 0, 0); settle(); settle(); chk(latched_off, 1, "R8 held");
    drive(0, 0, 0, 0, 0, 1); settle(); chk(latched_off, 0, "R11 thermal cleared");

    // R1 again via reset during activity
    drive(1, 2'b11, 2'b11, 2'b11, 0, 0);
    @(negedge clk); rst = 1'b1; cyc_stb = 0; uv_flag = 0; oc_flag = 0; ov_flag = 0;
    settle(); @(negedge clk); rst = 1'b0;
    chk(int'({conv_off, latched_off, ov_pulldown, uv_count, oc_count}), 0, "R1 reset mid-run");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule